// File: doc/BRIEF.md
# Valid-Bit Dequeue Ring Reader

This block drains a response ring that an outside producer writes. It walks the ring one slot at a time. For each slot it reads the verb byte and a two-bit status field through a ring-memory read port. It treats the slot as holding a new entry only when bit 7 of the verb matches the polarity it expects. A slot that holds a new entry is offered to a downstream client over a valid/ready handshake. When the client accepts it, the block pulses a consume strobe carrying the slot number and moves to the next slot. The expected polarity flips each time the slot counter wraps, so stale entries left from the previous lap never look new.

Older producer revisions do not clear their valid bits at reset. For that case a revision-select input picks a start-up fallback mode with a 4-slot ring. While fallback is active, no slot is read until a 4-bit producer index differs from the slot counter. Fallback ends for good once a new entry is found in the last slot. The block also classifies each accepted entry. A frame response whose status marks it both volatile and expired produces a release pulse, which frees the outstanding pull command.

The controller is a three-state machine:
- `ST_POLL` reads the current slot. It goes to `ST_LOOK` when a read is allowed and otherwise stays in `ST_POLL`.
- `ST_LOOK` compares the returned polarity. It goes to `ST_OFFER` when the entry is present and otherwise returns to `ST_POLL`.
- `ST_OFFER` holds the entry for the client. It goes back to `ST_POLL` on acceptance and otherwise stays in `ST_OFFER`.

Top module: `vb_ring_reader`

## Requirements
- R1: After a synchronous reset the slot counter is 0, the expected polarity is 1 and `ent_valid` is low. The fallback flag and the 4-slot depth are both taken from `legacy_rev`; with `legacy_rev` low the depth is 8.
- R2: The read address is `RING_BASE + slot*64`, with `RING_BASE` = 0x200 by default. A read is issued with `mem_rd_en`, and the data returns on the following cycle.
- R3: A slot is offered only if bit 7 of its verb equals the expected polarity. Otherwise nothing is offered and the same slot is polled again.
- R4: While `ent_valid` is high and `ent_ready` is low, the offered verb, status and index stay stable. The slot counter advances only on acceptance.
- R5: Accepting the entry in the last slot returns the counter to 0 and inverts the expected polarity.
- R6: In fallback mode no read is issued while the 4-bit `producer_idx` equals the slot counter.
- R7: Fallback mode clears when a new entry is found in slot depth-1 and never sets again until reset. After that, `producer_idx` is ignored.
- R8: The response type is verb AND 0x7F, and a frame response has type 0x60. On acceptance, `pull_release` pulses if and only if the type is 0x60 and both status bits are set: bit 0 means expired and bit 1 means volatile.
- R9: On acceptance, `consume_strobe` pulses for one cycle. `consume_idx` carries bits [8:6] of the accepted slot's address.
- R10: With `legacy_rev` high the ring is 4 slots deep, so the counter wraps after slot 3. With `legacy_rev` low it wraps after slot 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| legacy_rev | input | 1 | Selects the 4-slot ring with start-up fallback (sampled at reset) |
| producer_idx | input | 4 | Producer index, used only in fallback mode |
| mem_rd_en | output | 1 | Ring read request |
| mem_addr | output | 12 | Address of the slot being read |
| mem_verb | input | 8 | Verb byte returned one cycle after the read |
| mem_stat | input | 2 | Status bits returned with the verb (bit 0 expired, bit 1 volatile) |
| ent_valid | output | 1 | An entry is offered to the client |
| ent_ready | input | 1 | Client accepts the offered entry |
| ent_index | output | 3 | Slot number of the offered entry |
| ent_verb | output | 8 | Verb byte of the offered entry |
| ent_stat | output | 2 | Status bits of the offered entry |
| consume_strobe | output | 1 | One-cycle pulse on acceptance |
| consume_idx | output | 3 | Slot index written with the consume strobe |
| pull_release | output | 1 | Pulse that frees the outstanding pull command |

## Verification
The bench uses the default parameters: an 8-slot deep ring, a 4-slot shallow ring, a base of 0x200 and a 64-byte stride. It runs the block once with `legacy_rev` low and once with it high. The low run reaches the 8-slot wrap with its polarity inversion, stale-entry rejection and release classification. The high run reaches producer-index gating, the fallback exit in slot 3, and the 4-slot wrap followed by an entry taken while the producer index would still have blocked it.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
    typedef enum logic [1:0] {
        ST_POLL  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_OFFER = 2'd2
    } rdr_state_t;

    localparam int STAT_W       = 2;
    localparam int STAT_EXPIRED = 0;
    localparam int STAT_VOLATILE = 1;
    localparam logic [6:0] TYPE_FRAME = 7'h60;
endpackage

// File: rtl/vbr_ptr.sv
module vbr_ptr #(
    parameter int DEEP    = 8,
    parameter int SHALLOW = 4,
    localparam int IDX_W  = $clog2(DEEP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             legacy_rev,
    input  logic             advance,
    input  logic             clear_fb,
    output logic [IDX_W-1:0] next_idx,
    output logic             exp_pol,
    output logic             fallback,
    output logic             last_slot
);
    logic shallow;

    assign last_slot = shallow ? (next_idx == IDX_W'(SHALLOW - 1))
                               : (next_idx == IDX_W'(DEEP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx <= '0;
            exp_pol  <= 1'b1;
            fallback <= legacy_rev;
            shallow  <= legacy_rev;
        end else begin
            if (clear_fb) begin
                fallback <= 1'b0;
            end
            if (advance) begin
                if (last_slot) begin
                    next_idx <= '0;
                    exp_pol  <= ~exp_pol;
                end else begin
                    next_idx <= next_idx + 1'b1;
                end
            end
        end
    end

    // R5: leaving the last slot wraps to 0 with inverted polarity
    a_r5_wrap_flip: assert property (@(posedge clk) disable iff (rst)
        (advance && last_slot) |=> (next_idx == '0 && exp_pol != $past(exp_pol)));

    // R7: fallback never comes back before reset
    a_r7_fallback_sticky: assert property (@(posedge clk) disable iff (rst)
        !fallback |=> !fallback);
endmodule

// File: rtl/vbr_detect.sv
module vbr_detect #(
    parameter int IDX_W = 3,
    parameter int PI_W  = 4
) (
    input  logic             fallback,
    input  logic [PI_W-1:0]  producer_idx,
    input  logic [IDX_W-1:0] next_idx,
    input  logic             exp_pol,
    input  logic             verb_vb,
    output logic             may_read,
    output logic             present
);
    logic [PI_W-1:0] idx_ext;

    assign idx_ext  = PI_W'(next_idx);
    assign may_read = !fallback || (producer_idx != idx_ext);
    assign present  = (verb_vb == exp_pol);
endmodule

// File: rtl/vbr_classify.sv
module vbr_classify
    import vbr_pkg::*;
(
    input  logic [6:0]        verb_type,
    input  logic [STAT_W-1:0] stat,
    output logic              is_frame,
    output logic              release_req
);
    assign is_frame    = (verb_type == TYPE_FRAME);
    assign release_req = is_frame && stat[STAT_VOLATILE] && stat[STAT_EXPIRED];
endmodule

// File: rtl/vb_ring_reader.sv
module vb_ring_reader
    import vbr_pkg::*;
#(
    parameter int              DEEP        = 8,
    parameter int              SHALLOW     = 4,
    parameter int              ADDR_W      = 12,
    parameter logic [11:0]     RING_BASE   = 12'h200,
    parameter int              ENTRY_SHIFT = 6,
    parameter int              PI_W        = 4,
    localparam int             IDX_W       = $clog2(DEEP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_rev,
    input  logic [PI_W-1:0]   producer_idx,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_verb,
    input  logic [STAT_W-1:0] mem_stat,
    output logic              ent_valid,
    input  logic              ent_ready,
    output logic [IDX_W-1:0]  ent_index,
    output logic [7:0]        ent_verb,
    output logic [STAT_W-1:0] ent_stat,
    output logic              consume_strobe,
    output logic [IDX_W-1:0]  consume_idx,
    output logic              pull_release
);
    rdr_state_t         state, state_nx;
    logic [IDX_W-1:0]   next_idx;
    logic               exp_pol, fallback, last_slot;
    logic               may_read, present, is_frame, release_req;
    logic               advance, clear_fb;
    logic [IDX_W-1:0]   held_slot;
    logic [IDX_W-1:0]   rd_slot;
    logic [7:0]         held_verb;
    logic [STAT_W-1:0]  held_stat;

    vbr_ptr #(.DEEP(DEEP), .SHALLOW(SHALLOW)) u_ptr (
        .clk(clk), .rst(rst), .legacy_rev(legacy_rev),
        .advance(advance), .clear_fb(clear_fb),
        .next_idx(next_idx), .exp_pol(exp_pol),
        .fallback(fallback), .last_slot(last_slot)
    );

    vbr_detect #(.IDX_W(IDX_W), .PI_W(PI_W)) u_detect (
        .fallback(fallback), .producer_idx(producer_idx),
        .next_idx(next_idx), .exp_pol(exp_pol),
        .verb_vb(mem_verb[7]), .may_read(may_read), .present(present)
    );

    vbr_classify u_class (
        .verb_type(held_verb[6:0]), .stat(held_stat),
        .is_frame(is_frame), .release_req(release_req)
    );

    assign mem_addr = RING_BASE + (ADDR_W'(next_idx) << ENTRY_SHIFT);
    assign rd_slot  = mem_addr[ENTRY_SHIFT+IDX_W-1:ENTRY_SHIFT];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_POLL;
        end else begin
            state <= state_nx;
        end
    end

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POLL:  if (may_read)  state_nx = ST_LOOK;
            ST_LOOK:  state_nx = present ? ST_OFFER : ST_POLL;
            ST_OFFER: if (ent_ready) state_nx = ST_POLL;
            default:  state_nx = ST_POLL;
        endcase
    end

    // capture of the found entry
    always_ff @(posedge clk) begin
        if (rst) begin
            held_slot <= '0;
            held_verb <= '0;
            held_stat <= '0;
        end else if (state == ST_LOOK && present) begin
            held_slot <= rd_slot;
            held_verb <= mem_verb;
            held_stat <= mem_stat;
        end
    end

    // outputs
    always_comb begin
        mem_rd_en      = 1'b0;
        ent_valid      = 1'b0;
        advance        = 1'b0;
        clear_fb       = 1'b0;
        consume_strobe = 1'b0;
        pull_release   = 1'b0;
        unique case (state)
            ST_POLL:  mem_rd_en = may_read;
            ST_LOOK:  clear_fb = present && fallback && last_slot;
            ST_OFFER: begin
                ent_valid      = 1'b1;
                advance        = ent_ready;
                consume_strobe = ent_ready;
                pull_release   = ent_ready && release_req;
            end
            default: ;
        endcase
    end

    assign ent_index   = held_slot;
    assign ent_verb    = held_verb;
    assign ent_stat    = held_stat;
    assign consume_idx = held_slot;

    // R3: an offered entry always carries the expected polarity
    a_r3_polarity_match: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> (ent_verb[7] == exp_pol));

    // R4: offer held stable while the client stalls
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && !ent_ready) |=>
            (ent_valid && $stable(ent_verb) && $stable(ent_index) && $stable(ent_stat)));

    // R4: counter does not move without acceptance
    a_r4_no_advance: assert property (@(posedge clk) disable iff (rst)
        !(ent_valid && ent_ready) |=> $stable(next_idx));

    // R6: gated read in fallback mode
    a_r6_gate_read: assert property (@(posedge clk) disable iff (rst)
        (fallback && producer_idx == PI_W'(next_idx)) |-> !mem_rd_en);

    // R8: a release only comes with an acceptance
    a_r8_release_on_accept: assert property (@(posedge clk) disable iff (rst)
        pull_release |-> (consume_strobe && is_frame));
endmodule

// File: tb/vb_ring_reader_bench.sv
module vb_ring_reader_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       legacy_rev = 1'b0;
    logic [3:0] producer_idx = 4'd0;
    logic       mem_rd_en;
    logic [11:0] mem_addr;
    logic [7:0] mem_verb = 8'h00;
    logic [1:0] mem_stat = 2'b00;
    logic       ent_valid;
    logic       ent_ready = 1'b0;
    logic [2:0] ent_index;
    logic [7:0] ent_verb;
    logic [1:0] ent_stat;
    logic       consume_strobe;
    logic [2:0] consume_idx;
    logic       pull_release;

    logic [7:0] vmem [8];
    logic [1:0] vstat [8];
    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vb_ring_reader u_vb_ring_reader (
        .clk(clk), .rst(rst), .legacy_rev(legacy_rev),
        .producer_idx(producer_idx), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_verb(mem_verb), .mem_stat(mem_stat),
        .ent_valid(ent_valid), .ent_ready(ent_ready),
        .ent_index(ent_index), .ent_verb(ent_verb), .ent_stat(ent_stat),
        .consume_strobe(consume_strobe), .consume_idx(consume_idx),
        .pull_release(pull_release)
    );

    // ring memory model, one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_verb <= vmem[3'((mem_addr - 12'h200) >> 6)];
            mem_stat <= vstat[3'((mem_addr - 12'h200) >> 6)];
        end
    end

    always @(negedge clk) if (mem_rd_en) rd_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic legacy);
        @(negedge clk);
        rst = 1'b1;
        legacy_rev = legacy;
        ent_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            vmem[i] = 8'h00;
            vstat[i] = 2'b00;
        end
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // wait for an offer, stall, accept, check strobes
    task automatic take(input int idx, input logic [7:0] verb, input bit rel, input string req);
        int waited = 0;
        while (!ent_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(ent_valid, req, int'(ent_valid), 1);
        check(ent_index == 3'(idx), req, int'(ent_index), idx);
        check(ent_verb == verb, req, int'(ent_verb), int'(verb));
        @(negedge clk);
        @(negedge clk);
        check(ent_valid && ent_index == 3'(idx) && ent_verb == verb, "R4",
              int'(ent_index), idx);
        ent_ready = 1'b1;
        #1;
        check(consume_strobe && consume_idx == 3'(idx), "R9", int'(consume_idx), idx);
        check(pull_release == rel, "R8", int'(pull_release), int'(rel));
        @(negedge clk);
        ent_ready = 1'b0;
        #1;
        check(!consume_strobe && !ent_valid, "R9", int'(consume_strobe), 0);
    endtask

    task automatic expect_empty(input int cycles, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (ent_valid) seen = 1'b1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        #1;
        check(!ent_valid && mem_addr == 12'h200 && !consume_strobe, "R1",
              int'(mem_addr), 12'h200);
    endtask

    task automatic t_normal_lap;
        for (int i = 0; i < 8; i++) vmem[i] = 8'h80 | 8'(i);
        for (int i = 0; i < 8; i++) begin
            take(i, 8'h80 | 8'(i), 1'b0, "R2");
            if (i == 2) check(mem_addr == 12'h2C0, "R2", int'(mem_addr), 12'h2C0);
        end
        check(mem_addr == 12'h200, "R10", int'(mem_addr), 12'h200);
        // stale entry with old polarity must not be offered
        expect_empty(10, "R3");
        check(mem_addr == 12'h200, "R3", int'(mem_addr), 12'h200);
        vmem[0] = 8'h05;
        take(0, 8'h05, 1'b0, "R5");
    endtask

    task automatic t_release;
        vmem[1] = 8'h60; vstat[1] = 2'b11;
        vmem[2] = 8'h60; vstat[2] = 2'b01;
        vmem[3] = 8'h61; vstat[3] = 2'b11;
        vmem[4] = 8'h60; vstat[4] = 2'b10;
        take(1, 8'h60, 1'b1, "R8");
        take(2, 8'h60, 1'b0, "R8");
        take(3, 8'h61, 1'b0, "R8");
        take(4, 8'h60, 1'b0, "R8");
    endtask

    task automatic t_fallback;
        do_reset(1'b1);
        producer_idx = 4'd0;
        vmem[0] = 8'hE0;
        @(negedge clk);
        rd_cnt = 0;
        expect_empty(10, "R6");
        check(rd_cnt == 0, "R6", rd_cnt, 0);
        producer_idx = 4'd1;
        take(0, 8'hE0, 1'b0, "R6");
        vmem[1] = 8'h81; vmem[2] = 8'h82; vmem[3] = 8'h83;
        producer_idx = 4'd4;
        take(1, 8'h81, 1'b0, "R6");
        take(2, 8'h82, 1'b0, "R6");
        take(3, 8'h83, 1'b0, "R7");
        check(mem_addr == 12'h200, "R10", int'(mem_addr), 12'h200);
        // producer index now equals the slot, but fallback has ended
        producer_idx = 4'd0;
        vmem[0] = 8'h60;
        take(0, 8'h60, 1'b0, "R7");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_normal_lap();
        t_release();
        t_fallback();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule